// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an already decoded addressing mode and its operand fields into the address that the memory stage or the branch logic will use next. Each mode has its own address calculation: a literal value passed through, a fixed absolute address, a register value used as a pointer, or an absolute base plus an unscaled register. The based-indexed form sums an absolute base, a base register, a shifted index register and a displacement. The unit also adds a signed offset to the program counter, and it handles push and pop through a stack pointer that it owns. With every result it reports how many memory accesses the instruction costs, and it raises a flush request when a PC-relative branch is taken.

The base and index operands come from a ten-entry register file that lives inside the unit. The register file has one write port and two combinational read ports. A request is presented for one cycle with `req_valid` high, and all of its results appear on the registered outputs one clock edge later. The stack pointer is updated on the same edge.

Top module: `agu_top`

## Requirements
- R1: After reset `out_valid`, `out_ea`, `out_accesses`, `out_flush`, `out_imm_valid` and `out_imm` are zero and `out_sp` is 0xFFFE.
- R2: Immediate mode (`req_mode`=0) gives `out_ea`=0, `out_imm_valid`=1, `out_imm`=`req_abs` and `out_accesses`=1. In every other mode `out_imm_valid` and `out_imm` are 0.
- R3: Direct mode (`req_mode`=1) gives `out_ea`=`req_abs` and `out_accesses`=2.
- R4: Register-indirect mode (`req_mode`=2) gives `out_ea`= register[`req_base_sel`] and `out_accesses`=2.
- R5: Indexed mode (`req_mode`=3) gives `out_ea`=`req_abs` + register[`req_idx_sel`] and `out_accesses`=2. `req_scale` is ignored in this mode.
- R6: Based-indexed mode (`req_mode`=4) gives `out_ea`=`req_abs` + register[`req_base_sel`] + (register[`req_idx_sel`] << `req_scale`) + `req_disp` and `out_accesses`=2. Scale codes 0..3 mean factors 1, 2, 4 and 8.
- R7: PC-relative mode (`req_mode`=5) gives `out_ea`=`req_pc` + sign-extended `req_off`, with `out_accesses`=1 and `out_flush`=`req_taken`. `out_flush` is 0 in every other mode.
- R8: Push (`req_mode`=6) gives `out_ea`= SP−2 and `out_accesses`=2, and SP becomes SP−2.
- R9: Pop (`req_mode`=7) gives `out_ea`= SP and `out_accesses`=2, and SP becomes SP+2.
- R10: All results appear exactly one clock edge after the request. A cycle with `req_valid`=0 gives `out_valid`=0 on the next edge and leaves SP unchanged.
- R11: The register file has ten registers, selectors 0..9. A write to selector 10..15 is ignored, and a read through selector 10..15 returns 0.
- R12: All address arithmetic, including the SP steps, wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register file write selector |
| wr_data | input | 16 | Register file write data |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Mode code 0..7 (see R2–R9) |
| req_abs | input | 16 | Absolute address or literal |
| req_disp | input | 16 | Displacement for based-indexed mode |
| req_base_sel | input | 4 | Base register selector |
| req_idx_sel | input | 4 | Index register selector |
| req_scale | input | 2 | Index shift amount |
| req_pc | input | 16 | Current program counter |
| req_off | input | 8 | Signed branch offset |
| req_taken | input | 1 | Branch is taken |
| out_valid | output | 1 | Registered result valid |
| out_ea | output | 16 | Effective address |
| out_accesses | output | 2 | Memory accesses needed (1 or 2) |
| out_flush | output | 1 | Pipeline flush for a taken branch |
| out_imm_valid | output | 1 | Result is a literal, not an address |
| out_imm | output | 16 | Literal value |
| out_sp | output | 16 | Current stack pointer |

## Verification
An error in the stack pointer shows on `out_sp` one edge after the push or pop that caused it. It also shows on `out_ea` for the next stack request, so the bench runs push and pop sequences back to back and crosses the wrap point. A corrupted register file entry shows only when a mode reads that entry. The vectors therefore read every register that was loaded, including the ignored selectors, and each mismatch appears in the cycle right after the request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W   = 16;
  localparam int OFF_W    = 8;
  localparam int SEL_W    = 4;
  localparam int NUM_REGS = 10;

  typedef enum logic [2:0] {
    M_IMM   = 3'd0,
    M_DIR   = 3'd1,
    M_RIND  = 3'd2,
    M_IDX   = 3'd3,
    M_BIDX  = 3'd4,
    M_PCREL = 3'd5,
    M_PUSH  = 3'd6,
    M_POP   = 3'd7
  } agu_mode_e;

  function automatic logic [ADDR_W-1:0] scale_index(input logic [ADDR_W-1:0] idx,
                                                    input logic [1:0] sh);
    return idx << sh;
  endfunction

  function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] off);
    return {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [1:0] access_count(input agu_mode_e m);
    return (m == M_IMM || m == M_PCREL) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NUM_REGS = agu_pkg::NUM_REGS,
  parameter int SEL_W    = agu_pkg::SEL_W,
  parameter int DATA_W   = agu_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_a_sel,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [SEL_W-1:0]  rd_b_sel,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))      regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_a_sel == SEL_W'(i)) rd_a_data = regs[i];
      if (rd_b_sel == SEL_W'(i)) rd_b_data = regs[i];
    end
  end
endmodule

// File: rtl/agu_stack_ptr.sv
module agu_stack_ptr #(
  parameter int                       ADDR_W   = agu_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0]        SP_RESET = 16'hFFFE,
  parameter logic [ADDR_W-1:0]        STEP     = 16'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic              pop_en,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] sp_dec
);
  assign sp_dec = sp_q - STEP;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= SP_RESET;
    else if (push_en) sp_q <= sp_dec;
    else if (pop_en)  sp_q <= sp_q + STEP;
  end

  // R8
  sp_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> sp_q == $past(sp_q) - STEP);
  // R9
  sp_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> sp_q == $past(sp_q) + STEP);
  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en || pop_en) |=> $stable(sp_q));
  // R8
  sp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en));
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int AW = agu_pkg::ADDR_W,
  parameter int OW = agu_pkg::OFF_W
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] abs_addr,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] idx_val,
  input  logic [1:0]    scale,
  input  logic [AW-1:0] pc,
  input  logic [OW-1:0] off,
  input  logic [AW-1:0] sp_cur,
  input  logic [AW-1:0] sp_dec,
  output logic [AW-1:0] ea,
  output logic [1:0]    accesses,
  output logic          imm_flag
);
  agu_mode_e m;
  assign m = agu_mode_e'(mode);

  always_comb begin
    ea       = '0;
    imm_flag = 1'b0;
    unique case (m)
      M_IMM:   imm_flag = 1'b1;
      M_DIR:   ea = abs_addr;
      M_RIND:  ea = base_val;
      M_IDX:   ea = abs_addr + idx_val;
      M_BIDX:  ea = abs_addr + base_val + scale_index(idx_val, scale) + disp;
      M_PCREL: ea = pc + sext_off(off);
      M_PUSH:  ea = sp_dec;
      M_POP:   ea = sp_cur;
      default: ea = '0;
    endcase
    accesses = access_count(m);
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = agu_pkg::ADDR_W,
  parameter int OW = agu_pkg::OFF_W,
  parameter int SW = agu_pkg::SEL_W,
  parameter int NR = agu_pkg::NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [AW-1:0] req_abs,
  input  logic [AW-1:0] req_disp,
  input  logic [SW-1:0] req_base_sel,
  input  logic [SW-1:0] req_idx_sel,
  input  logic [1:0]    req_scale,
  input  logic [AW-1:0] req_pc,
  input  logic [OW-1:0] req_off,
  input  logic          req_taken,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic [1:0]    out_accesses,
  output logic          out_flush,
  output logic          out_imm_valid,
  output logic [AW-1:0] out_imm,
  output logic [AW-1:0] out_sp
);
  logic [AW-1:0] base_val, idx_val, sp_dec, ea_n;
  logic [1:0]    acc_n;
  logic          imm_n;
  logic          push_ev, pop_ev, flush_ev;

  assign push_ev  = req_valid && req_mode == M_PUSH;
  assign pop_ev   = req_valid && req_mode == M_POP;
  assign flush_ev = req_valid && req_mode == M_PCREL && req_taken;

  agu_regfile #(.NUM_REGS(NR), .SEL_W(SW), .DATA_W(AW)) u_rf (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .rd_a_sel(req_base_sel), .rd_a_data(base_val),
    .rd_b_sel(req_idx_sel),  .rd_b_data(idx_val)
  );

  agu_stack_ptr #(.ADDR_W(AW)) u_sp (
    .clk, .rst_n, .push_en(push_ev), .pop_en(pop_ev),
    .sp_q(out_sp), .sp_dec(sp_dec)
  );

  agu_ea_calc #(.AW(AW), .OW(OW)) u_calc (
    .mode(req_mode), .abs_addr(req_abs), .disp(req_disp),
    .base_val, .idx_val, .scale(req_scale), .pc(req_pc), .off(req_off),
    .sp_cur(out_sp), .sp_dec, .ea(ea_n), .accesses(acc_n), .imm_flag(imm_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      out_valid     <= 1'b0;
      out_ea        <= '0;
      out_accesses  <= '0;
      out_flush     <= 1'b0;
      out_imm_valid <= 1'b0;
      out_imm       <= '0;
    end else begin
      out_valid     <= 1'b1;
      out_ea        <= ea_n;
      out_accesses  <= acc_n;
      out_flush     <= flush_ev;
      out_imm_valid <= imm_n;
      out_imm       <= imm_n ? req_abs : '0;
    end
  end

  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R2
  imm_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_imm_valid |-> out_valid && out_ea == '0 && out_accesses == 2'd1);
  // R7
  flush_single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_flush |-> out_valid && out_accesses == 2'd1 && !out_imm_valid);
  // R8
  push_ea_is_new_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> out_ea == out_sp && out_accesses == 2'd2);
  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_accesses == 2'd1 || out_accesses == 2'd2));
endmodule

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic [15:0] req_abs, req_disp, req_pc;
  logic [3:0]  req_base_sel, req_idx_sel;
  logic [1:0]  req_scale;
  logic [7:0]  req_off;
  logic        req_taken;
  logic        out_valid, out_flush, out_imm_valid;
  logic [15:0] out_ea, out_imm, out_sp;
  logic [1:0]  out_accesses;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  agu_top u_dut (.*);

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] abs_a;
    logic [15:0] disp;
    logic [3:0]  bsel;
    logic [3:0]  isel;
    logic [1:0]  sc;
    logic [15:0] pc;
    logic [7:0]  off;
    logic        tk;
    logic [15:0] x_ea;
    logic [1:0]  x_acc;
    logic        x_fl;
    logic        x_imm;
  } vec_t;

  localparam int NV = 13;
  // registers preloaded: R1=0002 R2=1000 R3=2000 R5=0030 R7=4000 R8=0003 R9=FFF0
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h000A, 16'h0,    4'd0,  4'd0, 2'd0, 16'h0,    8'h00, 1'b0, 16'h0000, 2'd1, 1'b0, 1'b1}, // R2
    '{3'd1, 16'h3C00, 16'h0,    4'd0,  4'd0, 2'd0, 16'h0,    8'h00, 1'b0, 16'h3C00, 2'd2, 1'b0, 1'b0}, // R3
    '{3'd2, 16'h0,    16'h0,    4'd2,  4'd0, 2'd0, 16'h0,    8'h00, 1'b0, 16'h1000, 2'd2, 1'b0, 1'b0}, // R4
    '{3'd3, 16'h2000, 16'h0,    4'd0,  4'd5, 2'd3, 16'h0,    8'h00, 1'b0, 16'h2030, 2'd2, 1'b0, 1'b0}, // R5
    '{3'd4, 16'h1000, 16'h0008, 4'd7,  4'd8, 2'd2, 16'h0,    8'h00, 1'b0, 16'h5014, 2'd2, 1'b0, 1'b0}, // R6
    '{3'd4, 16'h0000, 16'h0004, 4'd3,  4'd1, 2'd0, 16'h0,    8'h00, 1'b0, 16'h2006, 2'd2, 1'b0, 1'b0}, // R6
    '{3'd4, 16'h0100, 16'h0000, 4'd0,  4'd8, 2'd3, 16'h0,    8'h00, 1'b0, 16'h0118, 2'd2, 1'b0, 1'b0}, // R6
    '{3'd4, 16'hFFF0, 16'h0020, 4'd9,  4'd1, 2'd1, 16'h0,    8'h00, 1'b0, 16'h0004, 2'd2, 1'b0, 1'b0}, // R12
    '{3'd5, 16'h0,    16'h0,    4'd0,  4'd0, 2'd0, 16'h0004, 8'h0A, 1'b1, 16'h000E, 2'd1, 1'b1, 1'b0}, // R7
    '{3'd5, 16'h0,    16'h0,    4'd0,  4'd0, 2'd0, 16'h0100, 8'hF0, 1'b0, 16'h00F0, 2'd1, 1'b0, 1'b0}, // R7
    '{3'd5, 16'h0,    16'h0,    4'd0,  4'd0, 2'd0, 16'hFFFE, 8'h04, 1'b1, 16'h0002, 2'd1, 1'b1, 1'b0}, // R12
    '{3'd2, 16'h0,    16'h0,    4'd12, 4'd0, 2'd0, 16'h0,    8'h00, 1'b0, 16'h0000, 2'd2, 1'b0, 1'b0}, // R11
    '{3'd3, 16'h0010, 16'h0,    4'd0,  4'd9, 2'd0, 16'h0,    8'h00, 1'b0, 16'h0000, 2'd2, 1'b0, 1'b0}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_req();
    req_valid = 0; req_mode = 0; req_abs = 0; req_disp = 0; req_pc = 0;
    req_base_sel = 0; req_idx_sel = 0; req_scale = 0; req_off = 0; req_taken = 0;
  endtask

  task automatic write_reg(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic stack_op(input logic [2:0] m, input logic [15:0] x_ea,
                          input logic [15:0] x_sp, input string req);
    @(negedge clk); req_valid = 1; req_mode = m;
    @(negedge clk); req_valid = 0;
    check(req, out_ea, x_ea, "stack ea");
    check(req, out_sp, x_sp, "stack sp");
    check(req, out_accesses, 2, "stack accesses");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; idle_req();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", out_valid, 0, "valid");
    check("R1", out_ea, 0, "ea");
    check("R1", out_imm_valid, 0, "imm_valid");
    check("R1", out_sp, 16'hFFFE, "sp");
    rst_n = 1;
    write_reg(1, 16'h0002); write_reg(2, 16'h1000); write_reg(3, 16'h2000);
    write_reg(5, 16'h0030); write_reg(7, 16'h4000); write_reg(8, 16'h0003);
    write_reg(9, 16'hFFF0);
    write_reg(12, 16'hBEEF); // R11: ignored selector
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1; req_mode = VECS[i].mode; req_abs = VECS[i].abs_a;
      req_disp = VECS[i].disp; req_base_sel = VECS[i].bsel; req_idx_sel = VECS[i].isel;
      req_scale = VECS[i].sc; req_pc = VECS[i].pc; req_off = VECS[i].off;
      req_taken = VECS[i].tk;
      @(negedge clk);
      idle_req();
      check($sformatf("R10 vec%0d", i), out_valid, 1, "valid");
      check($sformatf("mode%0d vec%0d", VECS[i].mode, i), out_ea, VECS[i].x_ea, "ea");
      check($sformatf("R3/R7 vec%0d", i), out_accesses, VECS[i].x_acc, "accesses");
      check($sformatf("R7 vec%0d", i), out_flush, VECS[i].x_fl, "flush");
      check($sformatf("R2 vec%0d", i), out_imm_valid, VECS[i].x_imm, "imm_valid");
      check($sformatf("R2 vec%0d", i), out_imm,
            VECS[i].x_imm ? VECS[i].abs_a : 16'h0, "imm");
      check("R10 sp", out_sp, 16'hFFFE, "sp untouched");
    end
    // R10: idle cycle
    @(negedge clk);
    check("R10", out_valid, 0, "idle valid");
    check("R10", out_sp, 16'hFFFE, "idle sp");
    // R8 / R9 / R12 stack sequence
    stack_op(3'd6, 16'hFFFC, 16'hFFFC, "R8");
    stack_op(3'd6, 16'hFFFA, 16'hFFFA, "R8");
    stack_op(3'd7, 16'hFFFA, 16'hFFFC, "R9");
    stack_op(3'd7, 16'hFFFC, 16'hFFFE, "R9");
    stack_op(3'd7, 16'hFFFE, 16'h0000, "R12");
    stack_op(3'd6, 16'hFFFE, 16'hFFFE, "R12");
    // R11: write to R9 still works after ignored write
    write_reg(9, 16'h0042);
    @(negedge clk); req_valid = 1; req_mode = 3'd2; req_base_sel = 4'd9;
    @(negedge clk); idle_req();
    check("R11", out_ea, 16'h0042, "R9 readback");
    // R1: reset mid-run restores SP
    stack_op(3'd6, 16'hFFFC, 16'hFFFC, "R8");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1", out_sp, 16'hFFFE, "sp after reset");
    check("R1", out_valid, 0, "valid after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule